// File: doc/BRIEF.md
# Interrupt entry and return unit

This unit owns the interrupt state of a small 8-bit accumulator processor. At every instruction boundary it looks at the opcode byte that is about to run, its immediate byte and a hardware interrupt request line. It then decides whether an interrupt entry, an interrupt return or a change of the interrupt-enable flag takes place. An entry saves the 16-bit program counter, the accumulator and the flags in a single shadow bank. It then writes back a program counter of zero, the interrupt code as the new accumulator, and the unchanged flags, and it clears the enable flag. A return writes the shadow bank back and sets the enable flag again.

Every interrupt lands at address zero. The handler tells the causes apart by the accumulator value, and zero is reserved for a cold start. The surrounding datapath presents its current register values on plain input ports. It takes the results from a write-back port that pulses once, in the last cycle of each operation. While an operation is running the unit holds `busy` and ignores the boundary strobe.

Top module: `irq_unit`

## Requirements
- R1: After reset `ie`, `busy` and `wr_en` are 0 and `wr_pc`, `wr_acc` and `wr_flags` are 0, so the first load gives accumulator code 0.
- R2: A boundary with opcode 8'h21 (software interrupt, immediate byte = code) is always accepted. It saves `cur_pc`+2, `cur_acc` and `cur_flags`, writes back pc 0, acc = code and flags = `cur_flags`, and leaves `ie` at 0 from the next cycle on.
- R3: A boundary with `hw_req` high while `ie` is 1 starts a hardware entry. It takes precedence over the opcode at that boundary, saves `cur_pc` itself, writes back pc 0 and acc = `hw_code`, and clears `ie`.
- R4: After the accepting edge `busy` is high for exactly 8 cycles (hardware entry), 7 cycles (software interrupt) or 4 cycles (return). `wr_en` is high only in the last of those cycles.
- R5: A boundary with opcode 8'h29 (return) writes back the saved pc, accumulator and flags and sets `ie`.
- R6: With `ie` at 0 a hardware request has no effect: `busy` and `wr_en` stay low. A software interrupt is still taken.
- R7: Opcode 8'h31 sets `ie` and opcode 8'h39 clears it, both from the next edge, without raising `busy`. Any other opcode has no effect.
- R8: A hardware request with code 0 is taken with accumulator code 8'hFF instead (default policy), so code 0 never reaches a handler from hardware.
- R9: While `busy` is high, boundary strobes, opcodes and requests are ignored. After an entry no hardware interrupt is accepted until a return or an enable-set opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| op_byte | input | 8 | Opcode of the next instruction |
| imm_byte | input | 8 | Byte following the opcode |
| hw_req | input | 1 | Hardware interrupt request |
| hw_code | input | 8 | Hardware interrupt code |
| cur_pc | input | 16 | Address of the opcode at the boundary |
| cur_acc | input | 8 | Current accumulator |
| cur_flags | input | 8 | Current flags |
| ie | output | 1 | Interrupt-enable flag |
| busy | output | 1 | Operation in progress |
| wr_en | output | 1 | Write-back strobe, last cycle of an operation |
| wr_pc | output | 16 | Program counter to load |
| wr_acc | output | 8 | Accumulator to load |
| wr_flags | output | 8 | Flags to load |

## Verification
The bench puts a hardware request and a software-interrupt opcode on the same boundary. A unit with the wrong priority would save the address after the instruction instead of the instruction's own address. It asserts requests while the enable flag is clear and checks that software interrupts still go through after a clear. An over-eager mask would lose them, and a missing mask would start a hardware entry. It holds the boundary strobe high with a live opcode through each busy window and checks that the operation's length and result stay unchanged. A unit that fails to lock would restart or overwrite the shadow bank. It also feeds a hardware code of zero, which a careless unit would pass on as the reserved boot code.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_HW   = 2'd1,
      OP_SW   = 2'd2,
      OP_RET  = 2'd3
   } irq_op_e;
endpackage

// File: rtl/irq_decide.sv
module irq_decide
   import irq_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter logic [7:0]  OPC_INT     = 8'h21,
   parameter logic [7:0]  OPC_RET     = 8'h29,
   parameter logic [7:0]  OPC_SET     = 8'h31,
   parameter logic [7:0]  OPC_CLR     = 8'h39,
   parameter bit          ZERO_IGNORE = 1'b0,
   parameter logic [7:0]  ZERO_SUBST  = 8'hFF
) (
   input  logic              boundary,
   input  logic              idle,
   input  logic              ie,
   input  logic              hw_req,
   input  logic [DATA_W-1:0] hw_code,
   input  logic [7:0]        op_byte,
   input  logic [DATA_W-1:0] imm_byte,
   output irq_op_e           op,
   output logic [DATA_W-1:0] code,
   output logic              set_ie,
   output logic              clr_ie
);
   logic              fire;
   logic              hw_ok;
   logic [DATA_W-1:0] hw_eff;

   assign fire = boundary && idle;

   generate
      if (ZERO_IGNORE) begin : g_zero_drop
         assign hw_ok  = hw_req && ie && (hw_code != '0);
         assign hw_eff = hw_code;
      end else begin : g_zero_swap
         assign hw_ok  = hw_req && ie;
         assign hw_eff = (hw_code == '0) ? DATA_W'(ZERO_SUBST) : hw_code;
      end
   endgenerate

   always_comb begin
      op     = OP_NONE;
      code   = '0;
      set_ie = 1'b0;
      clr_ie = 1'b0;
      if (fire) begin
         if (hw_ok) begin
            op   = OP_HW;
            code = hw_eff;
         end else begin
            unique case (op_byte)
               OPC_INT: begin
                  op   = OP_SW;
                  code = imm_byte;
               end
               OPC_RET: op     = OP_RET;
               OPC_SET: set_ie = 1'b1;
               OPC_CLR: clr_ie = 1'b1;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
   parameter int unsigned PC_W   = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned FLAG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [FLAG_W-1:0] flg_in,
   output logic [PC_W-1:0]   sh_pc,
   output logic [DATA_W-1:0] sh_acc,
   output logic [FLAG_W-1:0] sh_flg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_pc  <= '0;
         sh_acc <= '0;
         sh_flg <= '0;
      end else if (save) begin
         sh_pc  <= pc_in;
         sh_acc <= acc_in;
         sh_flg <= flg_in;
      end
   end

   // R9: the bank only changes on a save request
   a_r9_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !save |=> $stable(sh_pc) && $stable(sh_acc));
endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             busy,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (start)      cnt_q <= len;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == CNT_W'(1));

   a_r4_last_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> busy);
   a_r4_busy_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(last));
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);
endmodule

// File: rtl/irq_unit.sv
module irq_unit
   import irq_pkg::*;
#(
   parameter int unsigned PC_W        = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned FLAG_W      = 8,
   parameter int unsigned HW_LAT      = 8,
   parameter int unsigned SW_LAT      = 7,
   parameter int unsigned RET_LAT     = 4,
   parameter int unsigned INT_LEN     = 2,
   parameter bit          IE_RESET    = 1'b0,
   parameter bit          ZERO_IGNORE = 1'b0,
   parameter logic [7:0]  ZERO_SUBST  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic [7:0]        op_byte,
   input  logic [7:0]        imm_byte,
   input  logic              hw_req,
   input  logic [7:0]        hw_code,
   input  logic [15:0]       cur_pc,
   input  logic [7:0]        cur_acc,
   input  logic [7:0]        cur_flags,
   output logic              ie,
   output logic              busy,
   output logic              wr_en,
   output logic [15:0]       wr_pc,
   output logic [7:0]        wr_acc,
   output logic [7:0]        wr_flags
);
   localparam int unsigned MAX_LAT = (HW_LAT > SW_LAT) ?
                                     ((HW_LAT > RET_LAT) ? HW_LAT : RET_LAT) :
                                     ((SW_LAT > RET_LAT) ? SW_LAT : RET_LAT);
   localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

   generate
      if (PC_W != 16 || DATA_W != 8 || FLAG_W != 8) begin : g_bad_width
         $error("irq_unit: port widths are fixed at 16/8/8");
      end
      if (HW_LAT == 0 || SW_LAT == 0 || RET_LAT == 0) begin : g_bad_lat
         $error("irq_unit: every latency must be at least one cycle");
      end
      if (ZERO_SUBST == 8'h00) begin : g_bad_subst
         $error("irq_unit: substitute code must not be the boot code");
      end
   endgenerate

   irq_op_e           op;
   logic [DATA_W-1:0] code;
   logic              set_ie, clr_ie;
   logic              ie_q;
   logic              last;
   logic              entry;
   logic [PC_W-1:0]   save_pc;
   logic [PC_W-1:0]   sh_pc;
   logic [DATA_W-1:0] sh_acc;
   logic [FLAG_W-1:0] sh_flg;
   logic [CNT_W-1:0]  len;

   irq_decide #(
      .DATA_W(DATA_W), .ZERO_IGNORE(ZERO_IGNORE), .ZERO_SUBST(ZERO_SUBST)
   ) i_decide (
      .boundary(boundary), .idle(!busy), .ie(ie_q),
      .hw_req(hw_req), .hw_code(hw_code),
      .op_byte(op_byte), .imm_byte(imm_byte),
      .op(op), .code(code), .set_ie(set_ie), .clr_ie(clr_ie)
   );

   assign entry   = (op == OP_HW) || (op == OP_SW);
   assign save_pc = (op == OP_SW) ? cur_pc + PC_W'(INT_LEN) : cur_pc;

   irq_shadow #(
      .PC_W(PC_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W)
   ) i_shadow (
      .clk(clk), .rst_n(rst_n), .save(entry),
      .pc_in(save_pc), .acc_in(cur_acc), .flg_in(cur_flags),
      .sh_pc(sh_pc), .sh_acc(sh_acc), .sh_flg(sh_flg)
   );

   always_comb begin
      unique case (op)
         OP_HW:   len = CNT_W'(HW_LAT);
         OP_SW:   len = CNT_W'(SW_LAT);
         OP_RET:  len = CNT_W'(RET_LAT);
         default: len = '0;
      endcase
   end

   irq_timer #(.CNT_W(CNT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .start(op != OP_NONE), .len(len),
      .busy(busy), .last(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ie_q <= IE_RESET;
      else if (entry || clr_ie)      ie_q <= 1'b0;
      else if (op == OP_RET || set_ie) ie_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pc    <= '0;
         wr_acc   <= '0;
         wr_flags <= '0;
      end else if (entry) begin
         wr_pc    <= '0;
         wr_acc   <= code;
         wr_flags <= cur_flags;
      end else if (op == OP_RET) begin
         wr_pc    <= sh_pc;
         wr_acc   <= sh_acc;
         wr_flags <= sh_flg;
      end
   end

   assign ie    = ie_q;
   assign wr_en = last;

   a_r6_hw_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_HW) |-> ie_q);
   a_r2_entry_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> !ie_q);
   a_r5_return_sets_ie: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RET) |=> ie_q);
   a_r8_hw_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_HW) |=> (wr_acc != '0) && (wr_pc == '0));
   a_r9_busy_blocks_ops: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (op == OP_NONE) && !set_ie && !clr_ie);
endmodule

// File: tb/test_irq_unit.sv
module test_irq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary = 1'b0;
   logic [7:0]  op_byte = 8'h00, imm_byte = 8'h00, hw_code = 8'h00;
   logic        hw_req = 1'b0;
   logic [15:0] cur_pc = 16'h0;
   logic [7:0]  cur_acc = 8'h0, cur_flags = 8'h0;
   logic        ie, busy, wr_en;
   logic [15:0] wr_pc;
   logic [7:0]  wr_acc, wr_flags;

   int checks = 0;
   int errors = 0;

   // bench model
   bit          m_ie = 1'b0;
   bit          m_in_handler = 1'b0;
   logic [15:0] m_pc = 16'h0;
   logic [7:0]  m_acc = 8'h0, m_flg = 8'h0;

   always #10 clk = ~clk;

   irq_unit i_irq_unit (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .op_byte(op_byte),
      .imm_byte(imm_byte), .hw_req(hw_req), .hw_code(hw_code),
      .cur_pc(cur_pc), .cur_acc(cur_acc), .cur_flags(cur_flags),
      .ie(ie), .busy(busy), .wr_en(wr_en), .wr_pc(wr_pc),
      .wr_acc(wr_acc), .wr_flags(wr_flags)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int lat_of(input int kind);
      case (kind)
         1: return 8;
         2: return 7;
         3: return 4;
         default: return 0;
      endcase
   endfunction

   // 0 none, 1 hw, 2 sw, 3 return, 4 set, 5 clear
   function automatic int kind_of(input logic [7:0] opb, input bit hr);
      if (hr && m_ie) return 1;
      case (opb)
         8'h21: return 2;
         8'h29: return 3;
         8'h31: return 4;
         8'h39: return 5;
         default: return 0;
      endcase
   endfunction

   // called just after a negedge; leaves just after a negedge
   task automatic run_op(input logic [7:0] opb, input logic [7:0] imm,
                         input bit hr, input logic [7:0] hc,
                         input logic [15:0] pc, input logic [7:0] acc,
                         input logic [7:0] fl, input bit poke, input string req);
      int          kind;
      int          lat;
      logic [15:0] e_pc;
      logic [7:0]  e_acc, e_flg;
      kind = kind_of(opb, hr);
      lat  = lat_of(kind);
      e_pc = 16'h0; e_acc = 8'h0; e_flg = fl;
      case (kind)
         1: begin
            e_acc = (hc == 8'h00) ? 8'hFF : hc;
            m_pc = pc; m_acc = acc; m_flg = fl; m_ie = 1'b0; m_in_handler = 1'b1;
         end
         2: begin
            e_acc = imm;
            m_pc = pc + 16'd2; m_acc = acc; m_flg = fl; m_ie = 1'b0; m_in_handler = 1'b1;
         end
         3: begin
            e_pc = m_pc; e_acc = m_acc; e_flg = m_flg; m_ie = 1'b1; m_in_handler = 1'b0;
         end
         4: m_ie = 1'b1;
         5: m_ie = 1'b0;
         default: ;
      endcase
      boundary = 1'b1; op_byte = opb; imm_byte = imm; hw_req = hr; hw_code = hc;
      cur_pc = pc; cur_acc = acc; cur_flags = fl;
      @(posedge clk);
      @(negedge clk);
      if (!poke) begin
         boundary = 1'b0; hw_req = 1'b0;
      end else begin
         op_byte = 8'h21; imm_byte = 8'h5A; hw_req = 1'b1; hw_code = 8'h33;
         cur_pc = pc ^ 16'hFFFF; cur_acc = ~acc; cur_flags = ~fl;
      end
      if (lat == 0) begin
         boundary = 1'b0; hw_req = 1'b0;
         chk(busy == 1'b0, {req, " no busy"}, busy, 0);
         chk(wr_en == 1'b0, {req, " no write"}, wr_en, 0);
         chk(ie == m_ie, {req, " ie"}, ie, m_ie);
      end else begin
         for (int k = 1; k <= lat; k++) begin
            chk(busy == 1'b1, {req, " R4 busy"}, busy, 1);
            chk(wr_en == (k == lat), {req, " R4 wr_en"}, wr_en, (k == lat));
            if (k == lat) begin
               boundary = 1'b0; hw_req = 1'b0;
               chk(wr_pc == e_pc, {req, " pc"}, wr_pc, e_pc);
               chk(wr_acc == e_acc, {req, " acc"}, wr_acc, e_acc);
               chk(wr_flags == e_flg, {req, " flags"}, wr_flags, e_flg);
            end
            chk(ie == m_ie, {req, " ie"}, ie, m_ie);
            @(negedge clk);
         end
         chk(busy == 1'b0, {req, " R4 busy end"}, busy, 0);
         chk(wr_en == 1'b0, {req, " R4 single pulse"}, wr_en, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ie == 1'b0, "R1 ie", ie, 0);
      chk(busy == 1'b0 && wr_en == 1'b0, "R1 busy/wr_en", {busy, wr_en}, 0);
      chk(wr_pc == 16'h0 && wr_acc == 8'h0, "R1 pc/acc", {wr_pc, wr_acc}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 hw masked while ie is clear
      run_op(8'h00, 8'h00, 1'b1, 8'h44, 16'h0100, 8'h11, 8'h22, 1'b0, "R6 masked hw");
      // R2 / R6 software interrupt taken with ie clear
      run_op(8'h21, 8'h2A, 1'b0, 8'h00, 16'h0200, 8'h77, 8'h05, 1'b0, "R2 R6 sw while masked");
      // R5 return
      run_op(8'h29, 8'h00, 1'b0, 8'h00, 16'h0000, 8'h2A, 8'h00, 1'b0, "R5 return");
      // R7 clear then set, other opcode ignored
      run_op(8'h39, 8'h00, 1'b0, 8'h00, 16'h0300, 8'h00, 8'h00, 1'b0, "R7 clear");
      run_op(8'h31, 8'h00, 1'b0, 8'h00, 16'h0300, 8'h00, 8'h00, 1'b0, "R7 set");
      run_op(8'h5C, 8'h00, 1'b0, 8'h00, 16'h0300, 8'h00, 8'h00, 1'b0, "R7 other opcode");
      // R3 hw beats sw at the same boundary, R9 poke during busy
      run_op(8'h21, 8'h10, 1'b1, 8'h66, 16'h1234, 8'hA5, 8'h3C, 1'b1, "R3 R9 hw priority");
      // R9 hw not accepted after entry
      run_op(8'h00, 8'h00, 1'b1, 8'h67, 16'h0010, 8'h00, 8'h00, 1'b0, "R9 no nesting");
      run_op(8'h29, 8'h00, 1'b0, 8'h00, 16'h0020, 8'h66, 8'h00, 1'b1, "R5 R9 return poked");
      // R8 hardware code zero
      run_op(8'h00, 8'h00, 1'b1, 8'h00, 16'h0400, 8'h01, 8'h02, 1'b0, "R8 zero code");
      run_op(8'h29, 8'h00, 1'b0, 8'h00, 16'h0000, 8'hFF, 8'h00, 1'b0, "R5 return after R8");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0]  opb;
         logic [15:0] pc;
         int          sel;
         sel = $urandom_range(0, 9);
         pc  = 16'($urandom);
         case (sel)
            0, 1: opb = 8'h21;
            2, 3: opb = 8'h29;
            4:    opb = m_in_handler ? 8'h39 : 8'h31;
            5:    opb = 8'h39;
            default: opb = 8'($urandom);
         endcase
         if (m_in_handler && opb == 8'h31) opb = 8'h00;
         run_op(opb, 8'($urandom), ($urandom_range(0, 2) == 0),
                8'($urandom), pc, 8'($urandom), 8'($urandom),
                ($urandom_range(0, 3) == 0), "R2 R3 R4 R5 R7 random");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule